// File: doc/BRIEF.md
# Mode-Banked Integer Register File

This block holds the integer operand registers of a 64-bit core: 31 writable registers and a hardwired zero at index 31. It also holds a bank of eight shadow registers. While a privileged-mode flag is active, the shadow bank takes the place of registers 8 to 14 and register 25 for every operand access. Privileged handler code therefore gets scratch registers without saving the interrupted program's values.

Two combinational read ports and one clocked write port serve the instruction operands. A separate privileged side-port, addressed by privileged-register numbers 32 to 39, always reaches the normal copies of the eight banked registers, whatever the current mode. Handler code uses it to inspect or patch the interrupted program's state. The mode flag is registered and changes only on an instruction-group boundary strobe, so it stays fixed within a group.

Top module: `banked_regfile`

## Requirements
- R1: Reading index 31 on either read port returns zero, and an operand write to index 31 changes no register.
- R2: While the registered mode is 0, operand indices 0 to 30 read and write the normal registers. A value written through the operand port to index 8 to 14 or 25 is visible through the side-port.
- R3: While the registered mode is 1, operand indices 8 to 14 map to shadow entries 0 to 6 and index 25 maps to shadow entry 7. All other indices keep using the normal registers.
- R4: Shadow values cannot be reached while the mode is 0. They keep their contents across mode changes, and a value written in mode 1 is not seen at the same index after the mode returns to 0.
- R5: Side-port numbers 32 to 38 select normal registers 8 to 14 and number 39 selects normal register 25, in either mode. The side-port read is combinational and its write takes effect at the clock edge.
- R6: The registered mode `mode_q` takes the value of `priv_req` at a clock edge where `bound_strobe` is 1. It holds its value at every other edge. Writes in a cycle use the mode before that edge.
- R7: When an operand write and a side-port write hit the same physical register in one cycle, the side-port data is stored.
- R8: A side-port number outside 32 to 39 reads as zero, and a side-port write with such a number changes nothing.
- R9: A synchronous active-high reset clears all 39 physical registers and sets the mode to 0.
- R10: Both read ports return data in the same cycle for independent indices. An operand write becomes visible on the read ports only from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bound_strobe | input | 1 | Instruction-group boundary; loads the mode register |
| priv_req | input | 1 | Requested privileged mode, sampled on the boundary strobe |
| mode_q | output | 1 | Registered privileged mode in effect |
| rd_a_idx | input | 5 | Read port A register index |
| rd_a_data | output | XLEN | Read port A data |
| rd_b_idx | input | 5 | Read port B register index |
| rd_b_data | output | XLEN | Read port B data |
| wr_en | input | 1 | Operand write enable |
| wr_idx | input | 5 | Operand write index |
| wr_data | input | XLEN | Operand write data |
| side_num | input | PNUM_W | Privileged register number for the side-port |
| side_wr_en | input | 1 | Side-port write enable |
| side_wr_data | input | XLEN | Side-port write data |
| side_rd_data | output | XLEN | Side-port read data |

## Verification
An operand write and a side-port write can land on the same normal register in one cycle. This happens when the mode is 0, the operand index is 8 to 14 or 25, and the side-port number maps to that register. The bench provokes the collision both in its vector table and in a directed test, giving the two writes different data. The next cycle it reads the register back through both ports and expects the side-port data. In mode 1 the same pair of addresses must not collide, because the operand write then lands in the shadow entry, and the bench checks that both values survive.

// File: rtl/bankrf_pkg.sv
package bankrf_pkg;
  localparam int GPR_IDX_W   = 5;
  localparam int GPR_N       = 31;
  localparam int SHADOW_N    = 8;
  localparam int SHADOW_W    = $clog2(SHADOW_N);
  localparam int BANK_LO_BASE = 8;
  localparam int BANK_LO_N   = 7;
  localparam int BANK_HI_GPR = 25;
  localparam int SIDE_BASE   = 32;

  typedef struct packed {
    logic                hit;
    logic [SHADOW_W-1:0] slot;
  } bank_map_t;

  typedef struct packed {
    logic                 valid;
    logic [GPR_IDX_W-1:0] gpr;
  } side_map_t;

  // Which shadow entry, if any, replaces an operand index in privileged mode.
  function automatic bank_map_t bank_lookup(input logic [GPR_IDX_W-1:0] idx);
    bank_map_t m;
    int unsigned v;
    m = '0;
    v = 32'(idx);
    if (v >= BANK_LO_BASE && v < BANK_LO_BASE + BANK_LO_N) begin
      m.hit  = 1'b1;
      m.slot = SHADOW_W'(v - BANK_LO_BASE);
    end else if (v == BANK_HI_GPR) begin
      m.hit  = 1'b1;
      m.slot = SHADOW_W'(SHADOW_N - 1);
    end
    return m;
  endfunction

  // Which normal register a privileged side-port number reaches.
  function automatic side_map_t side_lookup(input int unsigned num);
    side_map_t s;
    int unsigned off;
    s = '0;
    if (num >= SIDE_BASE && num < SIDE_BASE + SHADOW_N) begin
      off     = num - SIDE_BASE;
      s.valid = 1'b1;
      s.gpr   = (off == SHADOW_N - 1) ? GPR_IDX_W'(BANK_HI_GPR)
                                      : GPR_IDX_W'(BANK_LO_BASE + off);
    end
    return s;
  endfunction
endpackage

// File: rtl/bankrf_mode.sv
module bankrf_mode (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  input  logic req,
  output logic mode_q
);
  always_ff @(posedge clk) begin
    if (rst)         mode_q <= 1'b0;
    else if (strobe) mode_q <= req;
  end
endmodule

// File: rtl/bankrf_xlate.sv
module bankrf_xlate import bankrf_pkg::*; #(
  parameter int PHYS_W = 6
) (
  input  logic [GPR_IDX_W-1:0] idx,
  input  logic                 mode,
  output logic [PHYS_W-1:0]    phys,
  output logic                 live
);
  bank_map_t m;
  always_comb begin
    m    = bank_lookup(idx);
    live = (idx != GPR_IDX_W'(GPR_N));
    if (!live)
      phys = '0;
    else if (mode && m.hit)
      phys = PHYS_W'(GPR_N) + PHYS_W'(m.slot);
    else
      phys = PHYS_W'(idx);
  end
endmodule

// File: rtl/bankrf_sidexlate.sv
module bankrf_sidexlate import bankrf_pkg::*; #(
  parameter int PNUM_W = 8,
  parameter int PHYS_W = 6
) (
  input  logic [PNUM_W-1:0] num,
  output logic [PHYS_W-1:0] phys,
  output logic              valid
);
  side_map_t s;
  always_comb begin
    s     = side_lookup(32'(num));
    valid = s.valid;
    phys  = PHYS_W'(s.gpr);
  end
endmodule

// File: rtl/bankrf_array.sv
module bankrf_array #(
  parameter int XLEN   = 64,
  parameter int DEPTH  = 39,
  parameter int NRD    = 3,
  parameter int PHYS_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              w0_en,
  input  logic [PHYS_W-1:0] w0_addr,
  input  logic [XLEN-1:0]   w0_data,
  input  logic              w1_en,
  input  logic [PHYS_W-1:0] w1_addr,
  input  logic [XLEN-1:0]   w1_data,
  input  logic [PHYS_W-1:0] raddr [NRD],
  output logic [XLEN-1:0]   rdata [NRD]
);
  logic [XLEN-1:0] mem [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst)                                  mem[e] <= '0;
      else if (w1_en && w1_addr == PHYS_W'(e))  mem[e] <= w1_data;
      else if (w0_en && w0_addr == PHYS_W'(e))  mem[e] <= w0_data;
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rdata[r] = mem[raddr[r]];
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile import bankrf_pkg::*; #(
  parameter int XLEN   = 64,
  parameter int PNUM_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bound_strobe,
  input  logic                 priv_req,
  output logic                 mode_q,
  input  logic [GPR_IDX_W-1:0] rd_a_idx,
  output logic [XLEN-1:0]      rd_a_data,
  input  logic [GPR_IDX_W-1:0] rd_b_idx,
  output logic [XLEN-1:0]      rd_b_data,
  input  logic                 wr_en,
  input  logic [GPR_IDX_W-1:0] wr_idx,
  input  logic [XLEN-1:0]      wr_data,
  input  logic [PNUM_W-1:0]    side_num,
  input  logic                 side_wr_en,
  input  logic [XLEN-1:0]      side_wr_data,
  output logic [XLEN-1:0]      side_rd_data
);
  localparam int PHYS_N = GPR_N + SHADOW_N;
  localparam int PHYS_W = $clog2(PHYS_N);
  localparam int NXL    = 3;   // read A, read B, operand write
  localparam int NRD    = 3;   // read A, read B, side read

  logic [GPR_IDX_W-1:0] xl_idx  [NXL];
  logic [PHYS_W-1:0]    xl_phys [NXL];
  logic                 xl_live [NXL];
  logic [PHYS_W-1:0]    side_phys;
  logic                 side_valid;
  logic [PHYS_W-1:0]    arr_addr [NRD];
  logic [XLEN-1:0]      arr_data [NRD];

  // Named internal events used by the checker.
  logic op_we;
  logic side_we;
  logic conflict_hit;

  bankrf_mode u_mode (
    .clk(clk), .rst(rst), .strobe(bound_strobe), .req(priv_req), .mode_q(mode_q)
  );

  assign xl_idx[0] = rd_a_idx;
  assign xl_idx[1] = rd_b_idx;
  assign xl_idx[2] = wr_idx;

  for (genvar p = 0; p < NXL; p++) begin : g_xl
    bankrf_xlate #(.PHYS_W(PHYS_W)) u_xl (
      .idx(xl_idx[p]), .mode(mode_q), .phys(xl_phys[p]), .live(xl_live[p])
    );
  end

  bankrf_sidexlate #(.PNUM_W(PNUM_W), .PHYS_W(PHYS_W)) u_side (
    .num(side_num), .phys(side_phys), .valid(side_valid)
  );

  assign op_we        = wr_en && xl_live[2];
  assign side_we      = side_wr_en && side_valid;
  assign conflict_hit = op_we && side_we && (xl_phys[2] == side_phys);

  assign arr_addr[0] = xl_phys[0];
  assign arr_addr[1] = xl_phys[1];
  assign arr_addr[2] = side_phys;

  bankrf_array #(.XLEN(XLEN), .DEPTH(PHYS_N), .NRD(NRD), .PHYS_W(PHYS_W)) u_arr (
    .clk(clk), .rst(rst),
    .w0_en(op_we && !conflict_hit), .w0_addr(xl_phys[2]), .w0_data(wr_data),
    .w1_en(side_we), .w1_addr(side_phys), .w1_data(side_wr_data),
    .raddr(arr_addr), .rdata(arr_data)
  );

  assign rd_a_data    = xl_live[0] ? arr_data[0] : '0;
  assign rd_b_data    = xl_live[1] ? arr_data[1] : '0;
  assign side_rd_data = side_valid ? arr_data[2] : '0;
endmodule

// File: rtl/bankrf_chk.sv
module bankrf_chk #(
  parameter int XLEN   = 64,
  parameter int PNUM_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bound_strobe,
  input logic              priv_req,
  input logic              mode_q,
  input logic [4:0]        rd_a_idx,
  input logic [XLEN-1:0]   rd_a_data,
  input logic [4:0]        rd_b_idx,
  input logic [XLEN-1:0]   rd_b_data,
  input logic [PNUM_W-1:0] side_num,
  input logic              side_we,
  input logic [XLEN-1:0]   side_wr_data,
  input logic [XLEN-1:0]   side_rd_data,
  input logic              side_valid,
  input logic              conflict_hit
);
  // R1
  zero_a_chk: assert property (@(posedge clk) disable iff (rst)
    rd_a_idx == 5'd31 |-> rd_a_data == '0);
  // R1
  zero_b_chk: assert property (@(posedge clk) disable iff (rst)
    rd_b_idx == 5'd31 |-> rd_b_data == '0);
  // R6
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bound_strobe |=> $stable(mode_q));
  // R6
  mode_load_chk: assert property (@(posedge clk) disable iff (rst)
    bound_strobe |=> mode_q == $past(priv_req));
  // R8
  side_bad_chk: assert property (@(posedge clk) disable iff (rst)
    !side_valid |-> side_rd_data == '0);
  // R5
  side_wr_chk: assert property (@(posedge clk) disable iff (rst)
    side_we |=> (side_num != $past(side_num)) || (side_rd_data == $past(side_wr_data)));
  // R7
  side_wins_chk: assert property (@(posedge clk) disable iff (rst)
    conflict_hit |=> (side_num != $past(side_num)) || (side_rd_data == $past(side_wr_data)));
  // R9
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mode_q == 1'b0) && (rd_a_data == '0) && (side_rd_data == '0));
endmodule

bind banked_regfile bankrf_chk #(.XLEN(XLEN), .PNUM_W(PNUM_W)) u_chk (
  .clk(clk), .rst(rst), .bound_strobe(bound_strobe), .priv_req(priv_req),
  .mode_q(mode_q), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
  .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .side_num(side_num),
  .side_we(side_we), .side_wr_data(side_wr_data), .side_rd_data(side_rd_data),
  .side_valid(side_valid), .conflict_hit(conflict_hit)
);

// File: tb/test_banked_regfile.sv
module test_banked_regfile;
  localparam int XLEN = 64;
  localparam int PW   = 8;
  localparam int NV   = 14;
  localparam int VW   = 43;

  // {strobe, priv, wen, widx[5], sen, snum[8], data[16], ra[5], rb[5]}
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0,1'b0,1'b1,5'd8, 1'b0,8'd0, 16'h1008,5'd8, 5'd31},
    {1'b0,1'b0,1'b1,5'd25,1'b0,8'd0, 16'h1025,5'd8, 5'd25},
    {1'b1,1'b1,1'b1,5'd3, 1'b0,8'd0, 16'h0003,5'd8, 5'd25},
    {1'b0,1'b0,1'b1,5'd8, 1'b0,8'd0, 16'h5008,5'd8, 5'd3},
    {1'b0,1'b0,1'b1,5'd25,1'b0,8'd32,16'h5025,5'd8, 5'd25},
    {1'b0,1'b0,1'b0,5'd0, 1'b1,8'd32,16'h2008,5'd8, 5'd25},
    {1'b0,1'b0,1'b0,5'd0, 1'b1,8'd39,16'h2025,5'd25,5'd8},
    {1'b1,1'b0,1'b1,5'd14,1'b1,8'd38,16'h3014,5'd14,5'd25},
    {1'b0,1'b0,1'b1,5'd14,1'b1,8'd38,16'h4014,5'd14,5'd8},
    {1'b0,1'b0,1'b1,5'd31,1'b1,8'd40,16'h7777,5'd31,5'd14},
    {1'b1,1'b1,1'b0,5'd0, 1'b1,8'd31,16'h0000,5'd14,5'd8},
    {1'b0,1'b0,1'b1,5'd9, 1'b0,8'd0, 16'h5009,5'd9, 5'd14},
    {1'b1,1'b0,1'b0,5'd0, 1'b0,8'd39,16'h0000,5'd9, 5'd8},
    {1'b0,1'b0,1'b0,5'd0, 1'b1,8'd33,16'h0000,5'd9, 5'd25}
  };

  logic clk = 1'b0;
  logic rst, bound_strobe, priv_req, mode_q, wr_en, side_wr_en;
  logic [4:0] rd_a_idx, rd_b_idx, wr_idx;
  logic [XLEN-1:0] rd_a_data, rd_b_data, wr_data, side_wr_data, side_rd_data;
  logic [PW-1:0] side_num;

  int checks = 0;
  int errors = 0;
  logic [XLEN-1:0] mdl [39];
  logic mdl_mode;
  string tag_force = "";

  always #2 clk = ~clk;

  banked_regfile #(.XLEN(XLEN), .PNUM_W(PW)) i_banked_regfile (
    .clk(clk), .rst(rst), .bound_strobe(bound_strobe), .priv_req(priv_req),
    .mode_q(mode_q), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .side_num(side_num), .side_wr_en(side_wr_en),
    .side_wr_data(side_wr_data), .side_rd_data(side_rd_data)
  );

  // Model slot: 0..30 normal, 31..38 shadow entries.
  function automatic int where(input logic m, input int i);
    if (!m) return i;
    case (i) inside
      [8:14]:  return 23 + i;
      25:      return 38;
      default: return i;
    endcase
  endfunction

  function automatic int side_where(input int n);
    if (n == 39) return 25;
    if (n >= 32 && n <= 38) return n - 24;
    return -1;
  endfunction

  task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic string rd_tag(input int i);
    if (tag_force != "") return tag_force;
    if (i == 31) return "R1 read";
    if (mdl_mode && where(1'b1, i) != i) return "R3 shadow read";
    return "R2 normal read";
  endfunction

  function automatic logic [XLEN-1:0] rd_exp(input int i);
    return (i == 31) ? '0 : mdl[where(mdl_mode, i)];
  endfunction

  task automatic step(input logic stb, input logic pr, input logic we, input int wi,
                      input logic [XLEN-1:0] wd, input logic se, input int sn,
                      input logic [XLEN-1:0] sd, input int ra, input int rb);
    int sp;
    @(negedge clk);
    bound_strobe = stb; priv_req = pr; wr_en = we; wr_idx = 5'(wi); wr_data = wd;
    side_wr_en = se; side_num = PW'(sn); side_wr_data = sd;
    rd_a_idx = 5'(ra); rd_b_idx = 5'(rb);
    #1;
    sp = side_where(sn);
    check(rd_tag(ra), rd_a_data, rd_exp(ra));
    check(rd_tag(rb), rd_b_data, rd_exp(rb));
    check(sp < 0 ? "R8 side read" : "R5 side read", side_rd_data, sp < 0 ? '0 : mdl[sp]);
    check("R6 mode", {63'd0, mode_q}, {63'd0, mdl_mode});
    @(posedge clk);
    if (we && wi != 31) mdl[where(mdl_mode, wi)] = wd;
    if (se && sp >= 0) mdl[sp] = sd;
    if (stb) mdl_mode = pr;
  endtask

  task automatic idle(input int ra, input int rb, input int sn);
    step(1'b0, 1'b0, 1'b0, 0, '0, 1'b0, sn, '0, ra, rb);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bound_strobe = 1'b0; wr_en = 1'b0; side_wr_en = 1'b0;
    @(posedge clk);
    for (int k = 0; k < 39; k++) mdl[k] = '0;
    mdl_mode = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; bound_strobe = 1'b0; priv_req = 1'b0; wr_en = 1'b0; wr_idx = '0;
    wr_data = '0; side_num = '0; side_wr_en = 1'b0; side_wr_data = '0;
    rd_a_idx = '0; rd_b_idx = '0;
    repeat (3) @(posedge clk);
    do_reset();

    // R9: everything reads zero after reset, mode clear
    tag_force = "R9 reset";
    for (int n = 32; n < 40; n++) idle(n - 24, 31 - (n - 32), n);
    tag_force = "";

    // Vector table
    for (int v = 0; v < NV; v++) begin
      logic [VW-1:0] e;
      e = VEC[v];
      step(e[42], e[41], e[40], int'(e[39:35]), {48'd0, e[25:10]},
           e[34], int'(e[33:26]), {16'hABCD, 32'd0, e[25:10]},
           int'(e[9:5]), int'(e[4:0]));
    end
    idle(8, 25, 32);

    // R7: collision in normal mode, side data kept
    do_reset();
    step(1'b0, 1'b0, 1'b1, 11, 64'h1111, 1'b1, 35, 64'h2222, 11, 11);
    @(negedge clk); #1;
    check("R7 side wins", rd_a_data, 64'h2222);
    // same addresses in privileged mode do not collide
    step(1'b1, 1'b1, 1'b0, 0, '0, 1'b0, 0, '0, 11, 11);
    step(1'b0, 1'b0, 1'b1, 11, 64'h3333, 1'b1, 35, 64'h4444, 11, 11);
    @(negedge clk); #1;
    check("R7 shadow op write", rd_a_data, 64'h3333);
    side_num = 8'd35; #1;
    check("R7 normal side write", side_rd_data, 64'h4444);

    // R4: shadow value hidden after mode clears, back after mode sets
    step(1'b1, 1'b0, 1'b0, 0, '0, 1'b0, 0, '0, 11, 11);
    @(negedge clk); rd_a_idx = 5'd11; #1;
    check("R4 hidden shadow", rd_a_data, 64'h4444);
    step(1'b1, 1'b1, 1'b0, 0, '0, 1'b0, 0, '0, 11, 11);
    @(negedge clk); rd_a_idx = 5'd11; #1;
    check("R4 shadow retained", rd_a_data, 64'h3333);

    // R10: write not visible same cycle, visible next on both ports
    step(1'b1, 1'b0, 1'b0, 0, '0, 1'b0, 0, '0, 5, 6);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'd5; wr_data = 64'h5555; rd_a_idx = 5'd5; rd_b_idx = 5'd5; #1;
    check("R10 same cycle old", rd_a_data, mdl[5]);
    @(posedge clk); mdl[5] = 64'h5555;
    @(negedge clk); wr_en = 1'b0; #1;
    check("R10 port A next", rd_a_data, 64'h5555);
    check("R10 port B next", rd_b_data, 64'h5555);

    // R1: write to 31 discarded
    step(1'b0, 1'b0, 1'b1, 31, 64'hFFFF, 1'b0, 0, '0, 31, 30);
    idle(31, 30, 0);

    // Random traffic against the model
    for (int c = 0; c < 600; c++) begin
      step(($urandom % 6) == 0, 1'($urandom), 1'($urandom), int'($urandom % 32),
           {$urandom, $urandom}, ($urandom % 3) == 0, int'(28 + $urandom % 14),
           {$urandom, $urandom}, int'($urandom % 32), int'($urandom % 32));
    end
    idle(8, 25, 39);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule